// File: doc/BRIEF.md
# Masked Repeating Alarm Comparator

This block holds four alarm bytes (seconds, minutes, hours and day of month, all BCD) and compares them against the running time of an external real-time counter. The compare happens once per one-second tick. Bit 7 of each alarm byte is a "don't care" mask. The pattern of the four mask bits sets how often the alarm repeats: monthly, daily, hourly, once a minute or every second.

A match sets a sticky alarm flag, which software clears by reading the status byte. When the interrupt-enable bit is on, a match also produces a one-cycle interrupt pulse. Software programs the alarm through a byte-wide register write port. It reads the status, the control byte and the alarm bytes back through a registered read port that has one cycle of latency.

Top module: `alarm_cmp_top`

## Requirements
- R1: After reset, `irq` and `alarm_flag` are 0 and every register reads back 0x00.
- R2: The alarm bytes sit at consecutive offsets, in a fixed order: 2 holds seconds, 3 minutes, 4 hours and 5 day of month. An accepted write stores the whole byte, including the bit 7 mask, and a read of the same offset returns that byte one cycle after `rd_en`.
- R3: A write to the seconds or minutes byte is kept only if bits 6:0 hold valid BCD from 00 to 59. Any other write leaves the stored byte unchanged.
- R4: A write to the hours byte is kept only if bits 5:0 hold valid BCD from 00 to 23. A write to the day byte is kept only if bits 5:0 hold valid BCD from 01 to 31. Any other write is ignored.
- R5: With all four masks clear, a tick matches only when seconds (bits 6:0), minutes (bits 6:0), hours (bits 5:0) and day (bits 5:0) are all equal to the current time.
- R6: Three mask patterns drop fields from the compare. With only the day mask set, the day is ignored (daily repeat). With day and hour masks set, the compare covers minutes and seconds only (hourly). With day, hour and minute masks set, only seconds are compared (per minute).
- R7: With all four masks set, or with any pattern other than those in R5 and R6, every tick is a match.
- R8: The compare is evaluated only when `tick` is high. A matching time with `tick` low changes neither `irq` nor the flag.
- R9: A match sets the alarm flag, which is bit 6 of the status byte at offset 0 and is also driven on `alarm_flag`. A read of offset 0 returns the flag as it was before the read, then clears it.
- R10: When a matching tick and a status read fall in the same cycle, the set takes priority. The read returns the old value and the flag stays 1.
- R11: `irq` is high for exactly the one cycle after a matching tick, and only when the enable bit (bit 0 of the control byte at offset 1) is 1. The flag is set whether or not the enable bit is on.
- R12: Writes to the status byte at offset 0 have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write offset |
| wr_data | input | 8 | Register write byte |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read offset |
| rd_data | output | 8 | Read byte, valid one cycle after rd_en |
| tick | input | 1 | One-cycle pulse, once per second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | One-cycle alarm interrupt pulse |

## Verification
The alarm flag can be set by a matching tick and cleared by a status read in the same clock cycle. The bench provokes this by raising `tick` and a read of offset 0 on the same falling edge, with every mask set so that the tick is certain to match. The bench then checks three things: the read data shows the pre-collision value 0x00, `irq` pulses, and the next status read returns 0x40. That last read proves the set won over the clear.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int BYTE_W   = 8;
  localparam int N_FIELDS = 4;   // seconds, minutes, hours, day
  localparam int MASK_BIT = 7;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    RATE_MONTH,
    RATE_DAY,
    RATE_HOUR,
    RATE_MIN,
    RATE_SEC
  } rate_e;

  // Bits of each alarm byte that take part in the compare
  localparam byte_t FIELD_BITS [N_FIELDS] = '{8'h7F, 8'h7F, 8'h3F, 8'h3F};
  // Legal BCD window for each alarm byte
  localparam byte_t FIELD_LO   [N_FIELDS] = '{8'h00, 8'h00, 8'h00, 8'h01};
  localparam byte_t FIELD_HI   [N_FIELDS] = '{8'h59, 8'h59, 8'h23, 8'h31};

  function automatic logic bcd_legal(input byte_t v, input byte_t lo, input byte_t hi);
    return (v[3:0] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/alarm_cmp_regs.sv
module alarm_cmp_regs
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int A_CTRL = 1,
  parameter int A_SEC  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  byte_t                       wr_data,
  output logic [N_FIELDS-1:0][BYTE_W-1:0] alm,
  output logic                        irq_en
);

  always_ff @(posedge clk) begin
    if (rst) irq_en <= 1'b0;
    else if (wr_en && wr_addr == ADDR_W'(A_CTRL)) irq_en <= wr_data[0];
  end

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
    logic hit_addr;
    logic legal;
    assign hit_addr = wr_en && (wr_addr == ADDR_W'(A_SEC + i));
    assign legal    = bcd_legal(wr_data & FIELD_BITS[i], FIELD_LO[i], FIELD_HI[i]);

    always_ff @(posedge clk) begin
      if (rst) alm[i] <= '0;
      else if (hit_addr && legal) alm[i] <= wr_data;
    end

    AST_FIELD_LEGAL: assert property (@(posedge clk) disable iff (rst)
      ((alm[i] & FIELD_BITS[i]) <= FIELD_HI[i]) && (alm[i][3:0] <= 4'd9)); // R3 R4

    AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (hit_addr && !legal) |=> $stable(alm[i])); // R3
  end

endmodule

// File: rtl/alarm_cmp_match.sv
module alarm_cmp_match
  import alarm_cmp_pkg::*;
(
  input  logic [N_FIELDS-1:0][BYTE_W-1:0] alm,
  input  logic [N_FIELDS-1:0][BYTE_W-1:0] now,
  output rate_e                           rate,
  output logic                            hit
);

  logic [N_FIELDS-1:0] fld_eq;
  logic [N_FIELDS-1:0] masks;

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_cmp
    assign fld_eq[i] = ((alm[i] ^ now[i]) & FIELD_BITS[i]) == '0;
    assign masks[i]  = alm[i][MASK_BIT];
  end

  // masks = {day, hour, min, sec}
  always_comb begin
    unique case (masks)
      4'b0000: rate = RATE_MONTH;
      4'b1000: rate = RATE_DAY;
      4'b1100: rate = RATE_HOUR;
      4'b1110: rate = RATE_MIN;
      default: rate = RATE_SEC;
    endcase
  end

  always_comb begin
    unique case (rate)
      RATE_MONTH: hit = &fld_eq;
      RATE_DAY:   hit = &fld_eq[2:0];
      RATE_HOUR:  hit = &fld_eq[1:0];
      RATE_MIN:   hit = fld_eq[0];
      default:    hit = 1'b1;
    endcase
  end

endmodule

// File: rtl/alarm_cmp_event.sv
module alarm_cmp_event (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hit,
  input  logic irq_en,
  input  logic clr_req,
  output logic flag,
  output logic irq
);

  logic set_req;
  assign set_req = tick && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= set_req && irq_en;
      if (set_req)      flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
    end
  end

  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(tick)); // R8

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en)); // R11

  AST_IRQ_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag); // R11

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (set_req && clr_req) |=> flag); // R10

  AST_NO_TICK_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !irq); // R8

endmodule

// File: rtl/alarm_cmp_top.sv
module alarm_cmp_top
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int A_FLAGS  = 0,
  parameter int A_CTRL   = 1,
  parameter int A_SEC    = 2,
  parameter int FLAG_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              tick,
  input  logic [7:0]        now_sec,
  input  logic [7:0]        now_min,
  input  logic [7:0]        now_hour,
  input  logic [7:0]        now_date,
  output logic              alarm_flag,
  output logic              irq
);

  logic [N_FIELDS-1:0][BYTE_W-1:0] alm;
  logic [N_FIELDS-1:0][BYTE_W-1:0] now;
  logic  irq_en;
  logic  hit;
  rate_e rate;
  logic  clr_req;
  byte_t rd_next;

  assign now     = {now_date, now_hour, now_min, now_sec};
  assign clr_req = rd_en && (rd_addr == ADDR_W'(A_FLAGS));

  alarm_cmp_regs #(.ADDR_W(ADDR_W), .A_CTRL(A_CTRL), .A_SEC(A_SEC)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .alm(alm), .irq_en(irq_en)
  );

  alarm_cmp_match match_i (
    .alm(alm), .now(now), .rate(rate), .hit(hit)
  );

  alarm_cmp_event event_i (
    .clk(clk), .rst(rst), .tick(tick), .hit(hit), .irq_en(irq_en),
    .clr_req(clr_req), .flag(alarm_flag), .irq(irq)
  );

  always_comb begin
    rd_next = '0;
    if (rd_addr == ADDR_W'(A_FLAGS)) rd_next[FLAG_BIT] = alarm_flag;
    if (rd_addr == ADDR_W'(A_CTRL))  rd_next[0] = irq_en;
    for (int i = 0; i < N_FIELDS; i++)
      if (rd_addr == ADDR_W'(A_SEC + i)) rd_next = alm[i];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr_req) |=> $stable(alarm_flag)); // R12

  AST_EVERY_TICK: assert property (@(posedge clk) disable iff (rst)
    (tick && rate == RATE_SEC && irq_en) |=> irq); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !tick) |=> !alarm_flag); // R9

endmodule

// File: tb/alarm_cmp_top_tb_top.sv
`timescale 1ns/1ps
module alarm_cmp_top_tb_top;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_date = '0;
  logic [7:0] rd_data;
  logic alarm_flag, irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  alarm_cmp_top #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_date(now_date),
    .alarm_flag(alarm_flag), .irq(irq)
  );

  // {alarm sec, min, hour, day, now sec, min, hour, day, expected match}
  localparam logic [64:0] VEC [10] = '{
    {8'h30, 8'h15, 8'h12, 8'h21, 8'h30, 8'h15, 8'h12, 8'h21, 1'b1}, // R5 month hit
    {8'h30, 8'h15, 8'h12, 8'h21, 8'h30, 8'h15, 8'h12, 8'h22, 1'b0}, // R5 day differs
    {8'h30, 8'h15, 8'h12, 8'hA1, 8'h30, 8'h15, 8'h12, 8'h05, 1'b1}, // R6 daily
    {8'h30, 8'h15, 8'h12, 8'hA1, 8'h30, 8'h15, 8'h13, 8'h21, 1'b0}, // R6 daily miss
    {8'h30, 8'h15, 8'h92, 8'h81, 8'h30, 8'h15, 8'h07, 8'h09, 1'b1}, // R6 hourly
    {8'h30, 8'h15, 8'h92, 8'h81, 8'h30, 8'h16, 8'h12, 8'h01, 1'b0}, // R6 hourly miss
    {8'h30, 8'h95, 8'h92, 8'h81, 8'h30, 8'h44, 8'h03, 8'h17, 1'b1}, // R6 per minute
    {8'h30, 8'h95, 8'h92, 8'h81, 8'h31, 8'h15, 8'h12, 8'h01, 1'b0}, // R6 minute miss
    {8'h80, 8'h80, 8'h80, 8'h81, 8'h07, 8'h33, 8'h22, 8'h19, 1'b1}, // R7 all masked
    {8'hB0, 8'h15, 8'h12, 8'h21, 8'h00, 8'h00, 8'h00, 8'h01, 1'b1}  // R7 odd pattern
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  // Pulses tick; returns irq as seen in the cycle after the tick edge
  task automatic pulse(output logic seen);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    seen = irq;
  endtask

  task automatic set_now(input logic [7:0] s, m, h, d);
    now_sec = s; now_min = m; now_hour = h; now_date = d;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 flag", {7'b0, alarm_flag}, 8'h00);
    rd(4'd0, v); chk("R1 status", v, 8'h00);
    rd(4'd1, v); chk("R1 ctrl", v, 8'h00);
    rd(4'd2, v); chk("R1 sec", v, 8'h00);
    rd(4'd5, v); chk("R1 day", v, 8'h00);

    // R2 readback with masks
    wr(4'd2, 8'hD9); rd(4'd2, v); chk("R2 sec", v, 8'hD9);
    wr(4'd3, 8'h45); rd(4'd3, v); chk("R2 min", v, 8'h45);
    wr(4'd4, 8'hA3); rd(4'd4, v); chk("R2 hour", v, 8'hA3);
    wr(4'd5, 8'h31); rd(4'd5, v); chk("R2 day", v, 8'h31);

    // R3 illegal seconds/minutes writes ignored
    wr(4'd2, 8'h60); rd(4'd2, v); chk("R3 sec 60", v, 8'hD9);
    wr(4'd2, 8'h1A); rd(4'd2, v); chk("R3 sec nibble", v, 8'hD9);
    wr(4'd3, 8'hE0); rd(4'd3, v); chk("R3 min 60", v, 8'h45);
    // R4 illegal hours/day writes ignored
    wr(4'd4, 8'h24); rd(4'd4, v); chk("R4 hour 24", v, 8'hA3);
    wr(4'd5, 8'h00); rd(4'd5, v); chk("R4 day 00", v, 8'h31);
    wr(4'd5, 8'h32); rd(4'd5, v); chk("R4 day 32", v, 8'h31);

    // Vector table, enable on
    wr(4'd1, 8'h01);
    for (int i = 0; i < 10; i++) begin
      wr(4'd2, VEC[i][64:57]);
      wr(4'd3, VEC[i][56:49]);
      wr(4'd4, VEC[i][48:41]);
      wr(4'd5, VEC[i][40:33]);
      set_now(VEC[i][32:25], VEC[i][24:17], VEC[i][16:9], VEC[i][8:1]);
      pulse(seen);
      chk($sformatf("R5 R6 R7 irq vec%0d", i), {7'b0, seen}, {7'b0, VEC[i][0]});
      rd(4'd0, v);
      chk($sformatf("R9 flag vec%0d", i), v, VEC[i][0] ? 8'h40 : 8'h00);
    end

    // R11 irq drops after one cycle (all masked, every tick matches)
    wr(4'd2, 8'h80); wr(4'd3, 8'h80); wr(4'd4, 8'h80); wr(4'd5, 8'h81);
    pulse(seen);
    chk("R11 irq high", {7'b0, seen}, 8'h01);
    @(negedge clk);
    chk("R11 irq one cycle", {7'b0, irq}, 8'h00);
    rd(4'd0, v); chk("R9 read returns set", v, 8'h40);
    rd(4'd0, v); chk("R9 cleared", v, 8'h00);

    // R8 no tick: nothing happens
    repeat (4) @(negedge clk);
    chk("R8 irq", {7'b0, irq}, 8'h00);
    rd(4'd0, v); chk("R8 flag", v, 8'h00);

    // R10 matching tick and status read in the same cycle
    @(negedge clk);
    tick = 1'b1; rd_en = 1'b1; rd_addr = 4'd0;
    @(negedge clk);
    tick = 1'b0; rd_en = 1'b0;
    chk("R10 read old", rd_data, 8'h00);
    chk("R10 irq", {7'b0, irq}, 8'h01);
    rd(4'd0, v); chk("R10 flag kept", v, 8'h40);

    // R11 disabled: flag still set, no irq
    wr(4'd1, 8'h00);
    pulse(seen);
    chk("R11 irq disabled", {7'b0, seen}, 8'h00);
    chk("R11 flag pin", {7'b0, alarm_flag}, 8'h01);

    // R12 writing status cannot clear or set the flag
    wr(4'd0, 8'h00);
    chk("R12 flag after write", {7'b0, alarm_flag}, 8'h01);
    rd(4'd0, v); chk("R12 status", v, 8'h40);
    wr(4'd0, 8'hFF);
    rd(4'd0, v); chk("R12 write ff", v, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule